// File: doc/BRIEF.md
# Peripheral-to-Memory DMA Channel with Double-Buffer Reload

This block is one channel of a peripheral DMA engine. Software programs an active memory pointer, an item count, a peripheral selection and an item size through a small register port. While the count is non-zero, each request from the selected peripheral becomes a single-beat write on the memory bus. After each write is accepted, the channel moves the pointer forward by the item size and lowers the count by one.

A second pointer and count form a reload pair. When the active count reaches zero, a non-zero reload count is moved into the active registers together with the reload pointer. Software can therefore refill one buffer while the channel fills the other. When both counts are exhausted, the channel stops. Two sticky status flags record count-zero events, and each flag can be routed to an interrupt line.

The memory side is a valid/ready master. Once `mem_valid` is raised, it stays high, and `mem_addr`, `mem_wdata` and `mem_size` stay unchanged, until the cycle in which `mem_ready` is high. Only one beat is in flight at a time. The slave may hold `mem_ready` low for any number of cycles. The peripheral acknowledge is raised in the same cycle as the accepted beat. A peripheral keeps its request high for as long as it still has items to deliver.

Top module: `pdma_chan`

## Requirements
- R1: After reset, all register indices read zero, and `mem_valid`, `per_ack` and `irq` are low.
- R2: When the active count is non-zero, no beat is in flight, and the request line picked by the select field is high at a clock edge, then from the next cycle `mem_valid` is high with `mem_addr` equal to the active pointer, `mem_wdata` equal to that peripheral's `per_data` slice sampled at that edge, and `mem_size` equal to the size field.
- R3: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_wdata` and `mem_size` hold their values.
- R4: `per_ack` has at most one bit set. Bit `sel` is high exactly in the cycles where `mem_valid` and `mem_ready` are both high.
- R5: Each accepted beat advances the pointer (index 0) by 1, 2 or 4 for size code 0, 1 or 2. Size code 3 steps by 4.
- R6: Each accepted beat lowers the active count (index 1) by one. Both the pointer and the count can be read at any time, including during a transfer.
- R7: When an accepted beat brings the count to zero and the reload count (index 3) is non-zero, the pointer takes the reload pointer (index 2), the count takes the reload count, and the reload count then reads zero.
- R8: When the count reaches zero with the reload count at zero, the channel stops. The pointer reads the address after the last item, and further requests on any line raise neither `mem_valid` nor `per_ack`.
- R9: Status (index 5): bit 0 is set at every count-zero event, and bit 1 is set when the count reaches zero with the reload count at zero. Writing 1 to a bit clears it.
- R10: `irq` is high whenever a status bit is set together with the matching bit of the mask register (index 6).
- R11: Writes to the pointer and count registers are ignored while the count is non-zero. Writing a non-zero count while stopped restarts the channel at the written pointer.
- R12: Configuration (index 4) holds the peripheral select in bits [3:0] and the size code in bits [9:8]. Requests on lines that are not selected start no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| per_req | input | NPER | Request lines, one per peripheral |
| per_data | input | NPER*DW | Data offered by each peripheral |
| per_ack | output | NPER | Acknowledge, one per peripheral |
| mem_valid | output | 1 | Memory beat valid |
| mem_ready | input | 1 | Memory beat accepted |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| mem_size | output | 2 | Size code of the beat |
| irq | output | 1 | Masked status interrupt |

## Verification
The alignment properties assume that software only loads pointers that are aligned to the size code in use, and that the size field is changed only while the channel is stopped. The stimulus respects both assumptions: every base address is a multiple of 64, and configuration is written only before the count is loaded. The bench also keeps the pointer and count writes that are meant to take effect within stopped periods. Writes issued while the channel is running are made on purpose, to show that they are ignored.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  localparam int REG_W = 32;

  localparam logic [2:0] RI_ADDR  = 3'd0;
  localparam logic [2:0] RI_CNT   = 3'd1;
  localparam logic [2:0] RI_RADDR = 3'd2;
  localparam logic [2:0] RI_RCNT  = 3'd3;
  localparam logic [2:0] RI_CFG   = 3'd4;
  localparam logic [2:0] RI_STAT  = 3'd5;
  localparam logic [2:0] RI_MASK  = 3'd6;

  localparam int CFG_SIZE_LSB = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef struct packed {
    logic all_done;
    logic tc_done;
  } flags_t;

  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_step = 3'd1;
      SZ_HALF: size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CW     = 16,
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [AW-1:0]     act_addr,
  input  logic [CW-1:0]     act_cnt,
  input  logic [AW-1:0]     rld_addr,
  input  logic [CW-1:0]     rld_cnt,
  input  logic              tc_evt,
  input  logic              all_evt,
  output logic              wr_addr,
  output logic              wr_cnt,
  output logic              wr_raddr,
  output logic              wr_rcnt,
  output logic [PSEL_W-1:0] cfg_sel,
  output logic [1:0]        cfg_size,
  output logic              irq
);

  flags_t flags_q;
  flags_t mask_q;
  flags_t clr;
  logic   unused_wbits;

  assign wr_addr  = reg_we && (reg_addr == RI_ADDR);
  assign wr_cnt   = reg_we && (reg_addr == RI_CNT);
  assign wr_raddr = reg_we && (reg_addr == RI_RADDR);
  assign wr_rcnt  = reg_we && (reg_addr == RI_RCNT);
  assign clr      = (reg_we && (reg_addr == RI_STAT)) ? flags_t'(reg_wdata[1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_sel  <= '0;
      cfg_size <= '0;
      mask_q   <= '0;
      flags_q  <= '0;
    end else begin
      if (reg_we && (reg_addr == RI_CFG)) begin
        cfg_sel  <= reg_wdata[PSEL_W-1:0];
        cfg_size <= reg_wdata[CFG_SIZE_LSB +: 2];
      end
      if (reg_we && (reg_addr == RI_MASK)) mask_q <= flags_t'(reg_wdata[1:0]);
      flags_q.tc_done  <= tc_evt  | (flags_q.tc_done  & ~clr.tc_done);
      flags_q.all_done <= all_evt | (flags_q.all_done & ~clr.all_done);
    end
  end

  assign irq = |(flags_q & mask_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RI_ADDR:  reg_rdata = REG_W'(act_addr);
      RI_CNT:   reg_rdata = REG_W'(act_cnt);
      RI_RADDR: reg_rdata = REG_W'(rld_addr);
      RI_RCNT:  reg_rdata = REG_W'(rld_cnt);
      RI_CFG: begin
        reg_rdata[CFG_SIZE_LSB +: 2] = cfg_size;
        reg_rdata[PSEL_W-1:0]        = cfg_sel;
      end
      RI_STAT:  reg_rdata[1:0] = flags_q;
      RI_MASK:  reg_rdata[1:0] = mask_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign unused_wbits = ^reg_wdata;

endmodule

// File: rtl/pdma_ctr.sv
module pdma_ctr #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   wdata,
  input  logic          wr_addr,
  input  logic          wr_cnt,
  input  logic          wr_raddr,
  input  logic          wr_rcnt,
  input  logic          hs,
  input  logic [2:0]    step,
  output logic [AW-1:0] act_addr,
  output logic [CW-1:0] act_cnt,
  output logic [AW-1:0] rld_addr,
  output logic [CW-1:0] rld_cnt,
  output logic          running,
  output logic          tc_evt,
  output logic          all_evt
);

  logic          last_item;
  logic          rld_ready;
  logic [AW-1:0] next_addr;
  logic          unused_hi;

  assign running   = (act_cnt != '0);
  assign last_item = hs && (act_cnt == CW'(1));
  assign rld_ready = (rld_cnt != '0);
  assign tc_evt    = last_item;
  assign all_evt   = last_item && !rld_ready;
  assign next_addr = act_addr + AW'(step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_addr <= '0;
      act_cnt  <= '0;
    end else if (hs) begin
      if (last_item && rld_ready) begin
        act_addr <= rld_addr;
        act_cnt  <= rld_cnt;
      end else begin
        act_addr <= next_addr;
        act_cnt  <= act_cnt - CW'(1);
      end
    end else if (!running) begin
      if (wr_addr) act_addr <= wdata[AW-1:0];
      if (wr_cnt)  act_cnt  <= wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_addr <= '0;
      rld_cnt  <= '0;
    end else begin
      if (wr_raddr) rld_addr <= wdata[AW-1:0];
      if (wr_rcnt)            rld_cnt <= wdata[CW-1:0];
      else if (last_item)     rld_cnt <= '0;
    end
  end

  assign unused_hi = ^wdata;

endmodule

// File: rtl/pdma_xfer.sv
module pdma_xfer #(
  parameter int NPER   = 4,
  parameter int DW     = 32,
  parameter int AW     = 32,
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic [PSEL_W-1:0] cfg_sel,
  input  logic [1:0]        cfg_size,
  input  logic [AW-1:0]     act_addr,
  input  logic [NPER-1:0]   per_req,
  input  logic [NPER*DW-1:0] per_data,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [1:0]        mem_size,
  output logic [NPER-1:0]   per_ack,
  output logic              hs
);

  logic              pend_q;
  logic [PSEL_W-1:0] sel_q;
  logic [1:0]        size_q;
  logic [DW-1:0]     data_q;
  logic              start;

  assign start = !pend_q && running && per_req[cfg_sel];
  assign hs    = pend_q && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sel_q  <= '0;
      size_q <= '0;
      data_q <= '0;
    end else if (start) begin
      pend_q <= 1'b1;
      sel_q  <= cfg_sel;
      size_q <= cfg_size;
      data_q <= per_data[cfg_sel*DW +: DW];
    end else if (hs) begin
      pend_q <= 1'b0;
    end
  end

  assign mem_valid = pend_q;
  assign mem_addr  = act_addr;
  assign mem_wdata = data_q;
  assign mem_size  = size_q;

  for (genvar g = 0; g < NPER; g++) begin : g_ack
    assign per_ack[g] = hs && (sel_q == PSEL_W'(g));
  end

endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
  import pdma_pkg::*;
#(
  parameter int NPER = 4,
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int DW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NPER-1:0]    per_req,
  input  logic [NPER*DW-1:0] per_data,
  output logic [NPER-1:0]    per_ack,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  output logic [1:0]         mem_size,
  output logic               irq
);

  localparam int PSEL_W = (NPER > 1) ? $clog2(NPER) : 1;

  logic              wr_addr, wr_cnt, wr_raddr, wr_rcnt;
  logic [PSEL_W-1:0] cfg_sel;
  logic [1:0]        cfg_size;
  logic [AW-1:0]     act_addr, rld_addr;
  logic [CW-1:0]     act_cnt, rld_cnt;
  logic              running, tc_evt, all_evt, hs;
  logic [2:0]        step;

  assign step = size_step(mem_size);

  pdma_regs #(.AW(AW), .CW(CW), .PSEL_W(PSEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .act_addr(act_addr), .act_cnt(act_cnt), .rld_addr(rld_addr), .rld_cnt(rld_cnt),
    .tc_evt(tc_evt), .all_evt(all_evt),
    .wr_addr(wr_addr), .wr_cnt(wr_cnt), .wr_raddr(wr_raddr), .wr_rcnt(wr_rcnt),
    .cfg_sel(cfg_sel), .cfg_size(cfg_size), .irq(irq)
  );

  pdma_ctr #(.AW(AW), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .wdata(reg_wdata),
    .wr_addr(wr_addr), .wr_cnt(wr_cnt), .wr_raddr(wr_raddr), .wr_rcnt(wr_rcnt),
    .hs(hs), .step(step),
    .act_addr(act_addr), .act_cnt(act_cnt), .rld_addr(rld_addr), .rld_cnt(rld_cnt),
    .running(running), .tc_evt(tc_evt), .all_evt(all_evt)
  );

  pdma_xfer #(.NPER(NPER), .DW(DW), .AW(AW), .PSEL_W(PSEL_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .running(running),
    .cfg_sel(cfg_sel), .cfg_size(cfg_size), .act_addr(act_addr),
    .per_req(per_req), .per_data(per_data), .mem_ready(mem_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_size(mem_size), .per_ack(per_ack), .hs(hs)
  );

endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk #(
  parameter int NPER = 4,
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [AW-1:0]   mem_addr,
  input logic [DW-1:0]   mem_wdata,
  input logic [1:0]      mem_size,
  input logic [NPER-1:0] per_ack,
  input logic [CW-1:0]   act_cnt
);

  // R3
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_size)));

  // R4
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_ack));

  // R4
  ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|per_ack) == (mem_valid && mem_ready)));

  // R6
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && act_cnt > CW'(1)) |=> (act_cnt == $past(act_cnt) - CW'(1)));

  // R8
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cnt == '0 && !mem_valid) |=> !mem_valid);

  // R5
  align_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_size == 2'd1) |-> !mem_addr[0]);

  // R5
  align_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_size[1]) |-> (mem_addr[1:0] == 2'b00));

endmodule

bind pdma_chan pdma_chan_chk #(.NPER(NPER), .AW(AW), .CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_size(mem_size),
  .per_ack(per_ack), .act_cnt(act_cnt)
);

// File: tb/pdma_chan_tb.sv
module pdma_chan_tb;

  localparam int NPER = 4;
  localparam int DW   = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NPER-1:0]   per_req = '0;
  logic [NPER*DW-1:0] per_data = '0;
  logic [NPER-1:0]   per_ack;
  logic              mem_valid;
  logic              mem_ready = 1'b0;
  logic [31:0]       mem_addr;
  logic [DW-1:0]     mem_wdata;
  logic [1:0]        mem_size;
  logic              irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int cur_sel, cur_size, cur_scen, item_idx;
  logic [31:0] exp_addr;

  always #5 clk = ~clk;

  pdma_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
    .per_data(per_data), .per_ack(per_ack), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_size(mem_size), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pdat(int p, int s, int i);
    return {8'(p), 8'(s), 16'(i)};
  endfunction

  function automatic int stepof(int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = idx;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic run_items(input int n);
    int avail = n;
    int guard = 0;
    bit stalled = 1'b0;
    while (avail > 0 && guard < 2000) begin
      @(negedge clk);
      guard++; cyc++;
      if (stalled) chk(mem_valid, "R3 valid held under stall", 32'(mem_valid), 32'd1);
      for (int p = 0; p < NPER; p++) begin
        per_req[p] = 1'b1;
        per_data[p*DW +: DW] = pdat(p, cur_scen, (p == cur_sel) ? item_idx : 999);
      end
      mem_ready = (cyc % 3) != 1;
      #1;
      stalled = mem_valid && !mem_ready;
      if (mem_valid && mem_ready) begin
        chk(mem_addr == exp_addr, "R5 beat address", mem_addr, exp_addr);
        chk(mem_wdata == pdat(cur_sel, cur_scen, item_idx), "R2 beat data (R12 selected line)",
            mem_wdata, pdat(cur_sel, cur_scen, item_idx));
        chk(mem_size == 2'(cur_size), "R2 beat size", 32'(mem_size), 32'(cur_size));
        chk(per_ack == NPER'(1 << cur_sel), "R4 ack line", 32'(per_ack), 32'(1 << cur_sel));
        exp_addr = exp_addr + 32'(stepof(cur_size));
        item_idx++;
        avail--;
      end else if (per_ack != '0) begin
        chk(1'b0, "R4 ack without beat", 32'(per_ack), 32'd0);
      end
    end
    if (avail > 0) chk(1'b0, "R2 items not moved", 32'(avail), 32'd0);
    @(negedge clk);
    per_req[cur_sel] = 1'b0;
    mem_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    chk(!mem_valid && per_ack == '0 && !irq, "R1 outputs after reset",
        {29'd0, mem_valid, |per_ack, irq}, 32'd0);
    for (int i = 0; i < 8; i++) rd_chk(3'(i), 32'd0, "R1 register reads zero");

    // Sweep: size x select x first length x reload length
    cur_scen = 0;
    for (int sz = 0; sz < 4; sz++)
      for (int sel = 0; sel < NPER; sel++)
        for (int len = 1; len <= 3; len++)
          for (int rlen = 0; rlen <= 2; rlen++) begin
            logic [31:0] base, rb;
            cur_scen++;
            cur_sel = sel; cur_size = sz; item_idx = 0;
            base = 32'h1000_0000 + 32'(cur_scen * 64);
            rb   = 32'h2000_0000 + 32'(cur_scen * 64);
            @(negedge clk); per_req = '0;
            wr(3'd4, (32'(sz) << 8) | 32'(sel));
            wr(3'd5, 32'd3);
            wr(3'd2, rb);
            wr(3'd3, 32'(rlen));
            wr(3'd0, base);
            wr(3'd1, 32'(len));
            rd_chk(3'd4, (32'(sz) << 8) | 32'(sel), "R12 config readback");
            exp_addr = base;
            run_items(len);
            if (rlen > 0) begin
              rd_chk(3'd1, 32'(rlen), "R7 count reloaded");
              rd_chk(3'd0, rb, "R7 pointer reloaded");
              rd_chk(3'd5, 32'd1, "R9 tc flag only");
              rd_chk(3'd3, 32'd0, "R7 reload count consumed");
              exp_addr = rb;
              run_items(rlen);
              rd_chk(3'd0, rb + 32'(rlen * stepof(sz)), "R5 final pointer after reload buffer");
            end else begin
              rd_chk(3'd0, base + 32'(len * stepof(sz)), "R8 final pointer");
            end
            rd_chk(3'd1, 32'd0, "R8 count at zero");
            rd_chk(3'd5, 32'd3, "R9 both flags set");
            for (int k = 0; k < 3; k++) begin
              @(negedge clk);
              per_req = '1; mem_ready = 1'b1;
              #1;
              chk(!mem_valid && per_ack == '0, "R8 stopped ignores requests",
                  {30'd0, mem_valid, |per_ack}, 32'd0);
            end
            @(negedge clk); per_req = '0; mem_ready = 1'b0;
          end

    // R11 / R6: writes while running are ignored, progress readable mid-run
    cur_scen = 200; cur_sel = 1; cur_size = 2; item_idx = 0;
    wr(3'd5, 32'd3);
    wr(3'd4, (32'd2 << 8) | 32'd1);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'h3000_0000);
    wr(3'd1, 32'd5);
    exp_addr = 32'h3000_0000;
    run_items(2);
    rd_chk(3'd1, 32'd3, "R6 count readable mid-run");
    rd_chk(3'd0, 32'h3000_0008, "R6 pointer readable mid-run");
    wr(3'd1, 32'd9);
    wr(3'd0, 32'hdead_0000);
    rd_chk(3'd1, 32'd3, "R11 count write ignored while running");
    rd_chk(3'd0, 32'h3000_0008, "R11 pointer write ignored while running");
    run_items(3);
    rd_chk(3'd0, 32'h3000_0014, "R11 pointer after remaining items");
    wr(3'd0, 32'h4000_0100);
    wr(3'd1, 32'd2);
    rd_chk(3'd1, 32'd2, "R11 restart count loaded");
    exp_addr = 32'h4000_0100;
    run_items(2);
    rd_chk(3'd0, 32'h4000_0108, "R11 restart pointer advanced");

    // R10 / R9: interrupt masking and write-1-to-clear
    wr(3'd6, 32'd0);
    #1 chk(!irq, "R10 irq masked off", 32'(irq), 32'd0);
    wr(3'd6, 32'd1);
    #1 chk(irq, "R10 irq from tc flag", 32'(irq), 32'd1);
    wr(3'd5, 32'd1);
    #1 chk(!irq, "R10 irq drops after clear", 32'(irq), 32'd0);
    rd_chk(3'd5, 32'd2, "R9 clear only bit 0");
    wr(3'd6, 32'd2);
    #1 chk(irq, "R10 irq from all-done flag", 32'(irq), 32'd1);
    wr(3'd5, 32'd2);
    #1 chk(!irq, "R10 irq after clearing bit 1", 32'(irq), 32'd0);
    rd_chk(3'd5, 32'd0, "R9 flags cleared");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule